// File: doc/BRIEF.md
# CAN Receive Buffer Pair with Rollover

This block holds the two receive message slots that follow the acceptance-filter stage of a CAN controller. The filter stage presents a frame that has already been accepted. The frame carries an identifier, a length code, the data bytes, the number of the filter that matched, and the slot it is aimed at. The block stores that frame in a single cycle. Each slot has a full flag, an interrupt flag and a recorded filter number. The full flag stays set until software releases the slot. Software-side strobes clear the flags and load the mode and the rollover enable.

When rollover is enabled, a frame aimed at slot 0 goes to slot 1 if slot 0 is occupied. A frame that finds no free slot is discarded. The discard shows as a one-cycle overflow pulse and as a sticky per-slot overflow flag. The stored contents of either slot can be read back through a registered read port.

Top module: `can_rxbuf_pair`

## Requirements
- R1: When `in_valid` is 1 and the target slot is free, the frame is written to that slot. The slot's `full`, `irq` and filter field then all update at the same clock edge. `in_target` = 0 aims at slot 0 and 1 aims at slot 1.
- R2: A set `full` bit stays 1 until its `clr_full` bit is pulsed. While it is set, no frame is written into that slot, and the slot's stored frame and filter field are unchanged.
- R3: When rollover is enabled and slot 0 is full, a frame aimed at slot 0 is written to slot 1, provided slot 1 is free. When rollover is disabled, a frame aimed at slot 0 is never written to slot 1.
- R4: If `irq` of a slot is cleared while its `full` stays set, the `irq` bit reads 0 for one cycle and then returns to 1. Clearing `full` and `irq` together leaves `irq` at 0.
- R5: In mode 0, slot 0 records only bit 0 of `in_fhit`, which is filter 1 versus filter 0. Slot 1 records bits 2:0 of `in_fhit`. The upper bits of both filter fields read 0.
- R6: In modes 1, 2 and 3, each slot records all 5 bits of `in_fhit`, the matched filter number 0 to 15.
- R7: `jtoff` equals the rollover enable while the mode is 0, and is 0 in any other mode.
- R8: A frame that finds no free slot is discarded and `ovf_pulse` is 1 for the following cycle. Which sticky flag is set depends on the frame. A frame aimed at slot 0 with rollover disabled sets `ovf_sticky[0]`. A frame aimed at slot 0 with rollover enabled, or a frame aimed at slot 1, sets `ovf_sticky[1]`.
- R9: A `clr_full` bit takes effect ahead of a frame arriving in the same cycle, so that frame is stored in the slot just released.
- R10: A synchronous active-high `rst` clears `full`, `irq`, both filter fields and `ovf_sticky`. It also selects mode 0 with rollover disabled.
- R11: `rd_id`, `rd_dlc` and `rd_data` present the frame stored in slot `rd_sel` one clock after `rd_sel` is applied.
- R12: `cfg_wr` loads `cfg_mode_in` as the mode and `cfg_roll_in` as the rollover enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepted frame present this cycle |
| in_target | input | 1 | Slot the frame is aimed at (0 or 1) |
| in_id | input | ID_W | Frame identifier |
| in_dlc | input | DLC_W | Frame length code |
| in_data | input | 8*DATA_BYTES | Frame data bytes |
| in_fhit | input | FHIT_W | Number of the matching filter |
| clr_full | input | 2 | Per-slot release strobe |
| clr_irq | input | 2 | Per-slot interrupt clear strobe |
| cfg_wr | input | 1 | Load mode and rollover enable |
| cfg_mode_in | input | 2 | Mode value to load |
| cfg_roll_in | input | 1 | Rollover enable value to load |
| rd_sel | input | 1 | Slot to read back |
| full | output | 2 | Per-slot occupied flag |
| irq | output | 2 | Per-slot interrupt flag |
| fhit0 | output | FHIT_W | Filter field of slot 0 |
| fhit1 | output | FHIT_W | Filter field of slot 1 |
| ovf_pulse | output | 1 | One-cycle discard indication |
| ovf_sticky | output | 2 | Per-slot sticky discard flag |
| jtoff | output | 1 | Mirror of rollover enable in mode 0 |
| rd_id | output | ID_W | Read-back identifier |
| rd_dlc | output | DLC_W | Read-back length code |
| rd_data | output | 8*DATA_BYTES | Read-back data bytes |

## Verification
Several frame patterns are applied:
- A frame into an empty slot 0 separates a correct store from a missing one.
- A second frame with rollover off shows whether a held full flag blocks the load.
- The same frame with rollover on shows whether it spills to slot 1.
- A frame with both slots full confirms the discard and which sticky flag it sets.
- A frame that arrives together with a `clr_full` strobe separates clear-before-load priority from the reverse order.
- Filter numbers with high bits set, such as 3, 13, 14 and 15, are sent in mode 0 and in the later modes. They distinguish the narrow legacy fields from the full-width ones.

// File: rtl/can_rxb_pkg.sv
package can_rxb_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_ENH1   = 2'd1,
    MODE_ENH2   = 2'd2,
    MODE_ENH3   = 2'd3
  } rxb_mode_e;

  localparam int unsigned SLOTS = 2;
endpackage

// File: rtl/can_rxb_route.sv
module can_rxb_route (
  input  logic       valid,
  input  logic       target,
  input  logic [1:0] free_n,
  input  logic       roll,
  output logic [1:0] store,
  output logic [1:0] drop
);
  always_comb begin
    store = 2'b00;
    drop  = 2'b00;
    if (valid) begin
      if (!target) begin
        if (!free_n[0])                store[0] = 1'b1;
        else if (roll && !free_n[1])   store[1] = 1'b1;
        else if (roll)                 drop[1]  = 1'b1;
        else                           drop[0]  = 1'b1;
      end else begin
        if (!free_n[1])                store[1] = 1'b1;
        else                           drop[1]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_rxb_flags.sv
module can_rxb_flags #(
  parameter int FHIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store,
  input  logic              clr_full,
  input  logic              clr_irq,
  input  logic              drop_here,
  input  logic [FHIT_W-1:0] fhit_in,
  output logic              full,
  output logic              irq,
  output logic              ovf,
  output logic [FHIT_W-1:0] fhit
);
  logic full_kept;
  assign full_kept = full & ~clr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      irq  <= 1'b0;
      ovf  <= 1'b0;
      fhit <= '0;
    end else begin
      if (store) begin
        full <= 1'b1;
        irq  <= 1'b1;
        fhit <= fhit_in;
      end else begin
        full <= full_kept;
        if (clr_irq)        irq <= 1'b0;
        else if (full_kept) irq <= 1'b1;
      end
      if (drop_here) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/can_rxb_store.sv
module can_rxb_store #(
  parameter int W     = 97,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_rxbuf_pair.sv
module can_rxbuf_pair #(
  parameter int ID_W       = 29,
  parameter int DLC_W      = 4,
  parameter int DATA_BYTES = 8,
  parameter int FHIT_W     = 5,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int FRAME_W   = ID_W + DLC_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_target,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DLC_W-1:0]  in_dlc,
  input  logic [DATA_W-1:0] in_data,
  input  logic [FHIT_W-1:0] in_fhit,
  input  logic [1:0]        clr_full,
  input  logic [1:0]        clr_irq,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_mode_in,
  input  logic              cfg_roll_in,
  input  logic              rd_sel,
  output logic [1:0]        full,
  output logic [1:0]        irq,
  output logic [FHIT_W-1:0] fhit0,
  output logic [FHIT_W-1:0] fhit1,
  output logic              ovf_pulse,
  output logic [1:0]        ovf_sticky,
  output logic              jtoff,
  output logic [ID_W-1:0]   rd_id,
  output logic [DLC_W-1:0]  rd_dlc,
  output logic [DATA_W-1:0] rd_data
);
  import can_rxb_pkg::*;

  localparam logic [FHIT_W-1:0] LEG_MASK0 = FHIT_W'(1);
  localparam logic [FHIT_W-1:0] LEG_MASK1 = FHIT_W'(7);

  rxb_mode_e mode_q;
  logic      roll_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_LEGACY;
      roll_q <= 1'b0;
    end else if (cfg_wr) begin
      mode_q <= rxb_mode_e'(cfg_mode_in);
      roll_q <= cfg_roll_in;
    end
  end

  assign jtoff = (mode_q == MODE_LEGACY) ? roll_q : 1'b0;

  logic [1:0] busy;
  logic [1:0] store;
  logic [1:0] drop;
  assign busy = full & ~clr_full;

  can_rxb_route u_route (
    .valid  (in_valid),
    .target (in_target),
    .free_n (busy),
    .roll   (roll_q),
    .store  (store),
    .drop   (drop)
  );

  logic [FHIT_W-1:0] fhit_fmt [2];
  logic [FHIT_W-1:0] fhit_arr [2];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic [FHIT_W-1:0] MASK = (g == 0) ? LEG_MASK0 : LEG_MASK1;
    assign fhit_fmt[g] = (mode_q == MODE_LEGACY) ? (in_fhit & MASK) : in_fhit;

    can_rxb_flags #(.FHIT_W(FHIT_W)) u_flags (
      .clk       (clk),
      .rst       (rst),
      .store     (store[g]),
      .clr_full  (clr_full[g]),
      .clr_irq   (clr_irq[g]),
      .drop_here (drop[g]),
      .fhit_in   (fhit_fmt[g]),
      .full      (full[g]),
      .irq       (irq[g]),
      .ovf       (ovf_sticky[g]),
      .fhit      (fhit_arr[g])
    );
  end

  assign fhit0 = fhit_arr[0];
  assign fhit1 = fhit_arr[1];

  always_ff @(posedge clk) begin
    if (rst) ovf_pulse <= 1'b0;
    else     ovf_pulse <= |drop;
  end

  logic [FRAME_W-1:0] rd_word;

  can_rxb_store #(.W(FRAME_W), .DEPTH(SLOTS)) u_store (
    .clk   (clk),
    .we    (|store),
    .waddr (store[1]),
    .wdata ({in_id, in_dlc, in_data}),
    .raddr (rd_sel),
    .rdata (rd_word)
  );

  assign {rd_id, rd_dlc, rd_data} = rd_word;
endmodule

// File: rtl/can_rxbuf_pair_chk.sv
module can_rxbuf_pair_chk #(
  parameter int FHIT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_target,
  input logic [1:0]        clr_full,
  input logic [1:0]        clr_irq,
  input logic              cfg_wr,
  input logic [1:0]        cfg_mode_in,
  input logic              cfg_roll_in,
  input logic [1:0]        full,
  input logic [1:0]        irq,
  input logic [FHIT_W-1:0] fhit0,
  input logic [FHIT_W-1:0] fhit1,
  input logic              ovf_pulse,
  input logic [1:0]        ovf_sticky,
  input logic              jtoff,
  input logic              roll_q
);
  assert_full_hold0_R2: assert property (@(posedge clk) disable iff (rst)
    full[0] && !clr_full[0] |=> full[0]);
  assert_full_hold1_R2: assert property (@(posedge clk) disable iff (rst)
    full[1] && !clr_full[1] |=> full[1]);
  assert_no_load0_R2: assert property (@(posedge clk) disable iff (rst)
    full[0] && !clr_full[0] |=> $stable(fhit0));
  assert_no_load1_R2: assert property (@(posedge clk) disable iff (rst)
    full[1] && !clr_full[1] |=> $stable(fhit1));
  assert_irq_back0_R4: assert property (@(posedge clk) disable iff (rst)
    !irq[0] && full[0] && !clr_full[0] && !clr_irq[0] |=> irq[0]);
  assert_irq_back1_R4: assert property (@(posedge clk) disable iff (rst)
    !irq[1] && full[1] && !clr_full[1] && !clr_irq[1] |=> irq[1]);
  assert_rollover_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_target && full[0] && !clr_full[0] && roll_q && !full[1]
    |=> full[1] && irq[1]);
  assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_target && full[0] && !clr_full[0] && !roll_q
    |=> ovf_pulse && ovf_sticky[0]);
  assert_jtoff_leg_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_mode_in == 2'd0 |=> jtoff == $past(cfg_roll_in));
  assert_jtoff_enh_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_mode_in != 2'd0 |=> !jtoff);
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> full == 2'b00 && irq == 2'b00 && ovf_sticky == 2'b00);
endmodule

bind can_rxbuf_pair can_rxbuf_pair_chk #(.FHIT_W(FHIT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_target   (in_target),
  .clr_full    (clr_full),
  .clr_irq     (clr_irq),
  .cfg_wr      (cfg_wr),
  .cfg_mode_in (cfg_mode_in),
  .cfg_roll_in (cfg_roll_in),
  .full        (full),
  .irq         (irq),
  .fhit0       (fhit0),
  .fhit1       (fhit1),
  .ovf_pulse   (ovf_pulse),
  .ovf_sticky  (ovf_sticky),
  .jtoff       (jtoff),
  .roll_q      (roll_q)
);

// File: tb/can_rxbuf_pair_bench.sv
module can_rxbuf_pair_bench;
  localparam int ID_W = 29, DLC_W = 4, DATA_W = 64, FHIT_W = 5;
  localparam int FW = ID_W + DLC_W + DATA_W;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_target = 0;
  logic [ID_W-1:0] in_id = '0;
  logic [DLC_W-1:0] in_dlc = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [FHIT_W-1:0] in_fhit = '0;
  logic [1:0] clr_full = 0, clr_irq = 0;
  logic cfg_wr = 0, cfg_roll_in = 0;
  logic [1:0] cfg_mode_in = 0;
  logic rd_sel = 0;
  logic [1:0] full, irq, ovf_sticky;
  logic [FHIT_W-1:0] fhit0, fhit1;
  logic ovf_pulse, jtoff;
  logic [ID_W-1:0] rd_id;
  logic [DLC_W-1:0] rd_dlc;
  logic [DATA_W-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_rxbuf_pair u_can_rxbuf_pair (.*);

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard: read requests push expected frames, monitor pops and compares
  logic [FW-1:0] exp_q[$];
  logic rd_req = 0, rd_pend = 0;
  string tag_q[$];

  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [FW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, 128'({rd_id, rd_dlc, rd_data}), 128'(e));
    end
  end

  task automatic rd_expect(logic sel, logic [FW-1:0] w, string tag);
    @(negedge clk);
    rd_sel = sel;
    rd_req = 1;
    exp_q.push_back(w);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 0;
  endtask

  function automatic logic [FW-1:0] fr(logic [ID_W-1:0] id, logic [DLC_W-1:0] d,
                                       logic [DATA_W-1:0] x);
    return {id, d, x};
  endfunction

  task automatic send(logic tgt, logic [FW-1:0] w, logic [FHIT_W-1:0] fh,
                      logic [1:0] clrf);
    @(negedge clk);
    in_valid = 1;
    in_target = tgt;
    {in_id, in_dlc, in_data} = w;
    in_fhit = fh;
    clr_full = clrf;
    @(negedge clk);
    in_valid = 0;
    clr_full = 0;
  endtask

  task automatic cfg(logic [1:0] m, logic r);
    @(negedge clk);
    cfg_wr = 1;
    cfg_mode_in = m;
    cfg_roll_in = r;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  initial begin
    logic [FW-1:0] f1, f2, f3, f4, f5, f6, f7, f8;
    f1 = fr(29'h0ABC123, 4'd8, 64'h1122334455667788);
    f2 = fr(29'h1000001, 4'd2, 64'h00000000DEADBEEF);
    f3 = fr(29'h0000777, 4'd5, 64'hA5A5A5A5A5A5A5A5);
    f4 = fr(29'h1FFFFFF, 4'd1, 64'h0F);
    f5 = fr(29'h0123456, 4'd7, 64'hCAFEF00D12345678);
    f6 = fr(29'h0000042, 4'd3, 64'h0102030405060708);
    f7 = fr(29'h0000099, 4'd4, 64'h9999);
    f8 = fr(29'h0000055, 4'd6, 64'h5555AAAA);

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 full", 128'(full), 0);
    chk("R10 irq", 128'(irq), 0);
    chk("R10 fhit", 128'({fhit0, fhit1}), 0);
    chk("R10 ovf", 128'({ovf_sticky, ovf_pulse}), 0);
    chk("R10 jtoff", 128'(jtoff), 0);

    // mode 0, empty slot 0, filter 3 -> only bit 0 kept
    send(0, f1, 5'd3, 2'b00);
    chk("R1 full", 128'(full), 2'b01);
    chk("R1 irq", 128'(irq), 2'b01);
    chk("R5 fhit0 legacy", 128'(fhit0), 1);
    rd_expect(0, f1, "R11 read slot0");

    // slot 0 full, rollover off -> discard
    send(0, f2, 5'd0, 2'b00);
    chk("R8 pulse", 128'(ovf_pulse), 1);
    chk("R8 sticky0", 128'(ovf_sticky), 2'b01);
    chk("R3 no spill", 128'(full), 2'b01);
    chk("R2 fhit0 kept", 128'(fhit0), 1);
    rd_expect(0, f1, "R2 slot0 unchanged");

    // enable rollover in mode 0
    cfg(2'd0, 1);
    chk("R7 jtoff legacy", 128'(jtoff), 1);

    // spill to slot 1, filter 14 -> bits 2:0 = 6
    send(0, f3, 5'd14, 2'b00);
    chk("R3 spill full", 128'(full), 2'b11);
    chk("R3 spill irq", 128'(irq), 2'b11);
    chk("R5 fhit1 legacy", 128'(fhit1), 6);
    chk("R8 no pulse", 128'(ovf_pulse), 0);
    rd_expect(1, f3, "R3 read slot1");

    // both full -> discard marks slot 1
    send(0, f4, 5'd2, 2'b00);
    chk("R8 pulse both", 128'(ovf_pulse), 1);
    chk("R8 sticky1", 128'(ovf_sticky), 2'b11);
    rd_expect(1, f3, "R2 slot1 unchanged");

    // clear irq while still full
    @(negedge clk);
    clr_irq = 2'b01;
    @(negedge clk);
    clr_irq = 0;
    chk("R4 irq low", 128'(irq), 2'b10);
    @(negedge clk);
    chk("R4 irq back", 128'(irq), 2'b11);

    // mode 1: jtoff off; release slot 0 in the same cycle as a frame
    cfg(2'd1, 1);
    chk("R7 jtoff enhanced", 128'(jtoff), 0);
    chk("R12 mode kept full", 128'(full), 2'b11);
    send(0, f5, 5'd13, 2'b01);
    chk("R9 stored after clear", 128'(full), 2'b11);
    chk("R6 fhit0 enh", 128'(fhit0), 13);
    chk("R9 no pulse", 128'(ovf_pulse), 0);
    rd_expect(0, f5, "R9 read slot0");

    // release both with irq clear
    @(negedge clk);
    clr_full = 2'b11;
    clr_irq = 2'b11;
    @(negedge clk);
    clr_full = 0;
    clr_irq = 0;
    chk("R2 released", 128'(full), 0);
    chk("R4 irq cleared", 128'(irq), 0);
    @(negedge clk);
    chk("R4 irq stays 0", 128'(irq), 0);

    // mode 2, direct slot 1 and slot 0
    cfg(2'd2, 0);
    send(1, f6, 5'd15, 2'b00);
    chk("R6 fhit1 enh", 128'(fhit1), 15);
    chk("R1 slot1 full", 128'(full), 2'b10);
    send(0, f7, 5'd9, 2'b00);
    chk("R6 fhit0 mode2", 128'(fhit0), 9);
    send(1, f8, 5'd4, 2'b00);
    chk("R8 slot1 drop pulse", 128'(ovf_pulse), 1);
    chk("R2 fhit1 kept", 128'(fhit1), 15);
    rd_expect(1, f6, "R11 read slot1");
    rd_expect(0, f7, "R11 read slot0 again");

    // reset clears everything
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10 full after", 128'(full), 0);
    chk("R10 sticky after", 128'(ovf_sticky), 0);
    chk("R10 fhit after", 128'({fhit0, fhit1}), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule